// File: doc/BRIEF.md
# Synchronous Burst Pseudo-SRAM Engine

This block is the device-side burst controller of a clocked pseudo-static RAM, with a small word array inside it. A host pulls chip enable low and pulses the address-valid strobe. On every rising clock edge where both are sampled low, the engine captures the start address and the write-enable level. That edge starts the latency count. After the configured number of clocks, it moves one word per clock between the data ports and the array. Reads come out registered on `dout`, marked by `dvalid`. Writes are sampled from `din`.

Consecutive transfers step the address by one. In the 8-word and 16-word lengths, the step wraps inside the aligned block that holds the start address. Those bursts end by themselves after the block length. In continuous mode the burst runs until chip enable is released, and the address rolls over from the top of the array to zero. A mode bit limits every write burst to a single word, while reads keep the configured length. Raising chip enable aborts any burst at once. A fresh strobe during a burst restarts it at the new address. The configuration is loaded directly through a one-cycle load pulse.

Top module: `sbpsram_engine`

## Requirements
- R1: After reset the engine is idle and `dvalid` is 0.
- R2: A start address is captured on an edge with `ce_n`=0 and `adv_n`=0. For a read, the word at that address is on `dout` with `dvalid`=1 right after the L-th rising edge following the capture edge, where L is the effective latency. Each following word comes one clock later.
- R3: The latency field `cfg_lat` gives L in clocks, from 2 to 7. The values 0 and 1 are treated as 2.
- R4: With `cfg_bl`=2'b00 the burst is 8 words. After offset 7 of the aligned 8-word block, the address wraps to offset 0 of the same block.
- R5: With `cfg_bl`=2'b01 the burst is 16 words. The address wraps inside the aligned 16-word block.
- R6: A fixed-length burst stops by itself after its word count. No further `dvalid` appears until a new strobe.
- R7: With `cfg_bl`=2'b10 or 2'b11 the burst is continuous and runs until `ce_n` goes high. Its address rolls from the last array word to 0.
- R8: When `ce_n` is sampled high, the burst stops at that edge, with no further transfer and no further `dvalid`.
- R9: A new strobe during an active burst restarts it. The latency and word count begin again at the newly captured address.
- R10: A write burst (`we_n`=0 at capture) stores `din` sampled at the same edges and addresses where a read would transfer.
- R11: With `cfg_single`=1 a write burst stores only its first word, whatever the length. Read bursts keep the configured length.
- R12: A rising edge with `cfg_load`=1 loads `cfg_bl`, `cfg_single` and `cfg_lat` as the active configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable sampled at capture, active low |
| addr | input | AW | Start word address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dvalid | output | 1 | Read word valid on `dout` |
| cfg_load | input | 1 | Load strobe for the configuration |
| cfg_bl | input | 2 | Burst length code: 00=8, 01=16, 1x=continuous |
| cfg_single | input | 1 | 1 = single-word writes |
| cfg_lat | input | 3 | Latency in clocks (2..7) |

## Verification
On every cycle, the assertions check three kinds of behaviour. The address counter stays inside its aligned block in the 8- and 16-word lengths and steps by one in continuous mode. A fixed-length burst never passes its word count, and a single-mode write ends after one word. A high chip enable leaves the engine idle with no valid data behind it. Other properties can only be shown by the bench's scenarios, which compare against a shadow of the array and track the cycle each word is due: the exact latency and clamping, the order of the data words, correct write contents, and the restart.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    BL_8     = 2'b00,
    BL_16    = 2'b01,
    BL_CONT  = 2'b10,
    BL_CONTX = 2'b11
  } blen_e;

  typedef struct packed {
    blen_e      bl;
    logic       single_wr;
    logic [2:0] lat;
  } cfg_t;

  localparam int unsigned LAT_MIN = 2;

  // effective latency: field values below the minimum are clamped
  function automatic logic [2:0] eff_lat(input logic [2:0] f);
    return (f < 3'(LAT_MIN)) ? 3'(LAT_MIN) : f;
  endfunction

  // words in a burst; 0 stands for "unbounded"
  function automatic logic [4:0] burst_words(input cfg_t c, input logic is_wr);
    if (is_wr && c.single_wr) return 5'd1;
    case (c.bl)
      BL_8:    return 5'd8;
      BL_16:   return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic is_cont(input blen_e b);
    return b[1];
  endfunction

endpackage

// File: rtl/sbp_cfg.sv
module sbp_cfg
  import sbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] bl_in,
  input  logic       single_in,
  input  logic [2:0] lat_in,
  output cfg_t       cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{bl: BL_8, single_wr: 1'b0, lat: 3'd2};
    end else if (load) begin
      cfg <= '{bl: blen_e'(bl_in), single_wr: single_in, lat: lat_in};
    end
  end

endmodule

// File: rtl/sbp_seq.sv
module sbp_seq
  import sbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic adv_n,
  input  logic we_n,
  input  cfg_t cfg,
  output logic start,
  output logic xfer,
  output logic wr_q,
  output logic busy
);

  logic [2:0] lcnt;
  logic [4:0] wcnt;
  logic [4:0] len;
  logic       lat_hit;
  logic       last;
  logic       run;

  assign start   = !ce_n && !adv_n;
  assign run     = busy && !ce_n && adv_n;
  assign lat_hit = (lcnt == eff_lat(cfg.lat));
  assign xfer    = run && lat_hit;
  assign len     = burst_words(cfg, wr_q);
  assign last    = (len != 5'd0) && (wcnt == len - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lcnt <= '0;
      wcnt <= '0;
      wr_q <= 1'b0;
    end else if (ce_n) begin
      busy <= 1'b0;
      lcnt <= '0;
      wcnt <= '0;
    end else if (!adv_n) begin
      busy <= 1'b1;
      lcnt <= 3'd1;
      wcnt <= '0;
      wr_q <= !we_n;
    end else if (busy) begin
      if (!lat_hit) begin
        lcnt <= lcnt + 3'd1;
      end else begin
        wcnt <= wcnt + 5'd1;
        if (last) busy <= 1'b0;
      end
    end
  end

  // R6: a bounded burst never counts past its length
  p_fixed_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && len != 5'd0) |-> (wcnt < len));

  // R8: a released chip enable leaves the sequencer idle
  p_ce_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !busy);

  // R11: single-write mode ends a write after one word
  p_single_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_q && cfg.single_wr) |=> !busy);

  // R9: a strobe always (re)starts the latency count
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && lcnt == 3'd1 && wcnt == 5'd0));

endmodule

// File: rtl/sbp_addr_ctr.sv
module sbp_addr_ctr
  import sbp_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic          step,
  input  blen_e         bl,
  output logic [AW-1:0] cur
);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input blen_e b);
    logic [AW-1:0] inc;
    inc = a + 1'b1;
    case (b)
      BL_8:    return {a[AW-1:3], inc[2:0]};
      BL_16:   return {a[AW-1:4], inc[3:0]};
      default: return inc;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= ld_addr;
    else if (step) cur <= next_addr(cur, bl);
  end

  // R4: 8-word bursts stay inside their aligned block
  p_wrap8_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && bl == BL_8) |=> (cur[AW-1:3] == $past(cur[AW-1:3])));

  // R5: 16-word bursts stay inside their aligned block
  p_wrap16_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && bl == BL_16) |=> (cur[AW-1:4] == $past(cur[AW-1:4])));

  // R7: continuous bursts walk the whole array, rolling over at the top
  p_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && is_cont(bl)) |=> (cur == AW'($past(cur) + 1'b1)));

endmodule

// File: rtl/sbp_array.sv
module sbp_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[a] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_en;
  end

endmodule

// File: rtl/sbpsram_engine.sv
module sbpsram_engine
  import sbp_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dvalid,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_bl,
  input  logic          cfg_single,
  input  logic [2:0]    cfg_lat
);

  cfg_t          cfg;
  logic          start;
  logic          xfer;
  logic          wr_q;
  logic          busy;
  logic          xfer_wr;
  logic          xfer_rd;
  logic [AW-1:0] cur;

  sbp_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .bl_in     (cfg_bl),
    .single_in (cfg_single),
    .lat_in    (cfg_lat),
    .cfg       (cfg)
  );

  sbp_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .adv_n (adv_n),
    .we_n  (we_n),
    .cfg   (cfg),
    .start (start),
    .xfer  (xfer),
    .wr_q  (wr_q),
    .busy  (busy)
  );

  sbp_addr_ctr #(.AW(AW)) u_actr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .ld_addr (addr),
    .step    (xfer),
    .bl      (cfg.bl),
    .cur     (cur)
  );

  assign xfer_wr = xfer && wr_q;
  assign xfer_rd = xfer && !wr_q;

  sbp_array #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (xfer_wr),
    .rd_en  (xfer_rd),
    .a      (cur),
    .wdata  (din),
    .rdata  (dout),
    .rvalid (dvalid)
  );

  // R8: valid read data only follows an edge with chip enable asserted
  p_dvalid_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(!ce_n));

  // R2: valid read data only follows an active burst
  p_dvalid_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(busy));

endmodule

// File: tb/sbpsram_engine_tb.sv
module sbpsram_engine_tb;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dvalid;
  logic          cfg_load = 1'b0;
  logic [1:0]    cfg_bl = 2'b00;
  logic          cfg_single = 1'b0;
  logic [2:0]    cfg_lat = 3'd2;

  always #2.5 clk = ~clk;

  sbpsram_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dvalid(dvalid),
    .cfg_load(cfg_load), .cfg_bl(cfg_bl), .cfg_single(cfg_single), .cfg_lat(cfg_lat)
  );

  int            checks = 0;
  int            fails = 0;
  int            cyc = 0;
  int            lat_b = 2;
  int            mode_b = 0;
  int            c0 = 0;
  string         tag = "R1";
  logic [DW-1:0] sh [N];
  int            qc [$];
  logic [DW-1:0] qd [$];

  always @(posedge clk) cyc <= cyc + 1;

  // bench view of the address sequence: mode 0=8-word, 1=16-word, 2=continuous
  function automatic int bnext(input int a, input int m);
    if (m == 0) return (a / 8) * 8 + (a % 8 + 1) % 8;
    if (m == 1) return (a / 16) * 16 + (a % 16 + 1) % 16;
    return (a + 1) % N;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dvalid) begin
      checks++;
      if (qc.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected dvalid, dout=%h exp none", tag, dout);
      end else begin
        int ec;
        logic [DW-1:0] ed;
        ec = qc.pop_front();
        ed = qd.pop_front();
        if (ec != cyc || dout !== ed) begin
          fails++;
          $display("FAIL %s: dout=%h at cycle %0d, exp %h at cycle %0d", tag, dout, cyc, ed, ec);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: cycle %0d exp < 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  task automatic set_cfg(input int bl, input bit single, input int lat);
    @(negedge clk);
    cfg_bl = 2'(bl); cfg_single = single; cfg_lat = 3'(lat); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    lat_b  = (lat < 2) ? 2 : lat;
    mode_b = (bl >= 2) ? 2 : bl;
  endtask

  task automatic strobe(input int a, input bit wr);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; we_n = !wr; addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    adv_n = 1'b1; we_n = 1'b1;
    c0 = cyc;
  endtask

  task automatic push_rd(input int a, input int n, input int base);
    int aa = a;
    for (int k = 0; k < n; k++) begin
      qc.push_back(base + lat_b + k);
      qd.push_back(sh[aa]);
      aa = bnext(aa, mode_b);
    end
  endtask

  task automatic rd(input int a, input int n);
    strobe(a, 1'b0);
    push_rd(a, n, c0);
    repeat (lat_b + n - 1) @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic wr(input int a, input int n, input int nreal, input int seed);
    int aa = a;
    strobe(a, 1'b1);
    repeat (lat_b - 1) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      din = DW'(seed * 131 + k * 17 + 3);
      if (k < nreal) sh[aa] = din;
      aa = bnext(aa, mode_b);
      @(posedge clk);
      @(negedge clk);
    end
    ce_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic drain_check();
    @(negedge clk);
    checks++;
    if (qc.size() != 0 || dvalid !== 1'b0) begin
      fails++;
      $display("FAIL %s: pending=%0d dvalid=%b, exp 0 and 0", tag, qc.size(), dvalid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    checks++;
    if (dvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1: dvalid=%b exp 0", dvalid);
    end

    // R12, R10, R7: fill the whole array with a continuous write
    tag = "R10";
    set_cfg(2, 1'b0, 3);
    wr(0, N, N, 1);
    tag = "R12";
    rd(5, 4);
    drain_check();

    // R2, R3, R4: 8-word read wrapping in its block
    tag = "R4";
    set_cfg(0, 1'b0, 2);
    rd(13, 8);
    drain_check();

    // R5, R3: 16-word read, longest latency
    tag = "R5";
    set_cfg(1, 1'b0, 7);
    rd(21, 16);
    drain_check();

    // R6: fixed burst ends alone even while ce_n stays low
    tag = "R6";
    set_cfg(0, 1'b0, 4);
    strobe(2, 1'b0);
    push_rd(2, 8, c0);
    repeat (lat_b + 12) @(posedge clk);
    drain_check();
    @(negedge clk);
    ce_n = 1'b1;

    // R7: continuous read across the array top
    tag = "R7";
    set_cfg(3, 1'b0, 4);
    rd(62, 6);
    drain_check();

    // R8: abort a 16-word read after three words
    tag = "R8";
    set_cfg(1, 1'b0, 3);
    rd(0, 3);
    repeat (20) @(posedge clk);
    drain_check();

    // R9: restart mid-burst
    tag = "R9";
    set_cfg(2, 1'b0, 3);
    strobe(10, 1'b0);
    push_rd(10, 2, c0);
    repeat (lat_b + 1) @(posedge clk);
    strobe(50, 1'b0);
    push_rd(50, 4, c0);
    repeat (lat_b + 3) @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(posedge clk);
    drain_check();

    // R3: latency field 0 is clamped to 2
    tag = "R3";
    set_cfg(0, 1'b0, 0);
    rd(33, 8);
    drain_check();

    // R10, R4: 8-word write wrapping, then read back
    tag = "R10";
    set_cfg(0, 1'b0, 5);
    wr(45, 8, 8, 7);
    rd(40, 8);
    drain_check();

    // R11: single-write mode stores one word; reads keep 16
    tag = "R11";
    set_cfg(1, 1'b1, 3);
    wr(3, 4, 1, 9);
    rd(0, 16);
    drain_check();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule